// File: doc/BRIEF.md
# Bus Buffer Link Controller

This block is the digital controller beside a bidirectional two-wire bus buffer. It decides when the input-side bus and the output-side bus are tied together. It watches the SDA and SCL levels of both sides, the power-good state, the presence of the output supply, an external fault flag and an enable pin. From these it drives a join command to the analog buffers, a READY indication, a precharge enable and an enable for the rise-time accelerators.

Both sides must be at a safe point before a join. A side is at a safe point after a STOP, or after both of its lines have stayed high for a programmable number of cycles. Either kind is accepted on either side. A change of the output supply forces a blanking interval of fixed length, and after it both sides must qualify again. A fault can separate the sides. Toggling the enable pin after a fault forces a join at once.

Top module: `bus_join_ctrl`

## Requirements
- R1: While `pwr_good_i` is low, `join_o`, `ready_o` and `accel_o` are 0 and `precharge_o` is 1, whatever the bus lines and `vout_ok_i` do. An output-supply change seen during this time does not start blanking.
- R2: The sides join only when `en_i` is high and each side is qualified. A side is qualified by a STOP or by bus idle, and it loses qualification when either of its lines goes low. A single qualified side never causes a join.
- R3: A STOP is SDA rising while SCL stays high, taken on samples resynchronized through `SYNC_STAGES` flops. The join follows no later than five clock cycles after the SDA pin rises.
- R4: Bus idle on a side means both of its lines are high for `IDLE_CYCLES` consecutive clock cycles.
- R5: When joined, `ready_o` is 1 and `precharge_o` is 0. `ready_o` is 0 whenever the sides are apart. Once cleared, `precharge_o` returns to 1 only during undervoltage lockout.
- R6: `accel_o` is fixed at the moment of joining. It is 1 when `acc_mode_i` is 2'b00 (pin low) or 2'b10 (pin open). It is 0 for 2'b01 (pin high) and for 2'b11. It is cleared on any separation, and a change of `acc_mode_i` while joined has no effect.
- R7: Any edge of `vout_ok_i` separates the sides and clears `accel_o`. Bus lines are then ignored for `(CLK_HZ/1000000)*BLANK_US` cycles, which is 4750 at the defaults. After that, both sides must qualify again. `precharge_o` is unchanged by this edge.
- R8: With `disc_on_fault_i` high, a rising `fault_i` while joined separates the sides. They stay apart while `fault_i` is high, and after it falls both sides must qualify again.
- R9: With `disc_on_fault_i` low, `fault_i` has no effect on the join.
- R10: If a fault has been seen since the last join, a rising `en_i` joins the sides at the next clock edge without qualification. An output-supply edge in the same cycle takes priority and starts blanking.
- R11: `en_i` low while joined separates the sides, and a new qualification is needed before the next join.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_sda_i | input | 1 | Input-side SDA level (asynchronous) |
| in_scl_i | input | 1 | Input-side SCL level (asynchronous) |
| out_sda_i | input | 1 | Output-side SDA level (asynchronous) |
| out_scl_i | input | 1 | Output-side SCL level (asynchronous) |
| en_i | input | 1 | Enable pin |
| pwr_good_i | input | 1 | Supply above lockout threshold |
| vout_ok_i | input | 1 | Output-side supply present |
| fault_i | input | 1 | Stuck-bus fault flag |
| disc_on_fault_i | input | 1 | Separate sides on fault |
| acc_mode_i | input | 2 | Accelerator pin state: 00 low, 01 high, 10 open, 11 treated as high |
| join_o | output | 1 | Connect the two sides |
| ready_o | output | 1 | Sides connected |
| precharge_o | output | 1 | Precharge enable |
| accel_o | output | 1 | Rise-time accelerator enable |

## Verification
The sharpest collision is an output-supply edge landing in the same cycle as an enable rising edge that would otherwise force a join after a fault. The bench provokes it by setting up the fault history, dropping enable with the input side held busy, and then raising enable and toggling the supply flag at the same falling clock edge. The join must stay off through the whole blanking interval, and must not follow even after it while the bus remains busy. A second overlap pairs a STOP on one side with idle on the other. The join must appear within a few cycles of that STOP, well before idle could have qualified the first side.

// File: rtl/bjc_pkg.sv
package bjc_pkg;

    typedef enum logic [2:0] {
        ST_LOCK  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_JOIN  = 3'd2,
        ST_BLANK = 3'd3,
        ST_FHOLD = 3'd4
    } link_state_e;

    typedef enum logic [1:0] {
        ACC_LOW  = 2'b00,
        ACC_HIGH = 2'b01,
        ACC_OPEN = 2'b10,
        ACC_RSVD = 2'b11
    } acc_mode_e;

    typedef struct packed {
        link_state_e st;
        logic        pre;
        logic        acc;
        logic        fault_seen;
        logic        en_prev;
        logic        fault_prev;
        logic        vout_prev;
    } core_regs_t;

    function automatic logic acc_allows(input logic [1:0] mode);
        return (mode == ACC_LOW) || (mode == ACC_OPEN);
    endfunction

endpackage

// File: rtl/bjc_sync.sv
module bjc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bjc_side_qual.sv
module bjc_side_qual #(
    parameter int IDLE_CYCLES = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic ok_o
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] IDLE_LIM = CNT_W'(IDLE_CYCLES);

    typedef struct packed {
        logic             sda_prev;
        logic             scl_prev;
        logic [CNT_W-1:0] cnt;
        logic             ok;
    } qual_regs_t;

    qual_regs_t q, d;
    logic busy, stop_seen, idle_seen;

    always_comb begin
        d          = q;
        busy       = !sda_i || !scl_i;
        stop_seen  = scl_i && q.scl_prev && sda_i && !q.sda_prev;
        idle_seen  = !busy && (q.cnt == IDLE_LIM);
        d.sda_prev = sda_i;
        d.scl_prev = scl_i;
        if (clear_i || busy)       d.cnt = '0;
        else if (q.cnt != IDLE_LIM) d.cnt = q.cnt + 1'b1;
        if (clear_i || busy)            d.ok = 1'b0;
        else if (stop_seen || idle_seen) d.ok = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{sda_prev: 1'b1, scl_prev: 1'b1, cnt: '0, ok: 1'b0};
        else         q <= d;
    end

    assign ok_o = q.ok;

    // R2: a side loses qualification after clear or bus activity
    p_clear_drops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_i || !sda_i || !scl_i) |=> !ok_o);

    // R3: SDA rising under a high SCL qualifies the side
    p_stop_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && sda_i && scl_i && $past(scl_i) && !$past(sda_i)) |=> ok_o);
endmodule

// File: rtl/bjc_blank_timer.sv
module bjc_blank_timer #(
    parameter int CYCLES = 4750
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R7: a load always opens a blanking window
    p_load_opens_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !expired_o);

    // R7: without a load an expired window stays expired
    p_stays_expired_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && expired_o) |=> expired_o);
endmodule

// File: rtl/bus_join_ctrl.sv
module bus_join_ctrl
    import bjc_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BLANK_US    = 95,
    parameter int IDLE_CYCLES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       in_sda_i,
    input  logic       in_scl_i,
    input  logic       out_sda_i,
    input  logic       out_scl_i,
    input  logic       en_i,
    input  logic       pwr_good_i,
    input  logic       vout_ok_i,
    input  logic       fault_i,
    input  logic       disc_on_fault_i,
    input  logic [1:0] acc_mode_i,
    output logic       join_o,
    output logic       ready_o,
    output logic       precharge_o,
    output logic       accel_o
);
    localparam int SIDES        = 2;
    localparam int LINES        = 2 * SIDES;
    localparam int BLANK_CYCLES = (CLK_HZ / 1_000_000) * BLANK_US;

    logic [LINES-1:0] raw_lines, sync_lines;
    logic [SIDES-1:0] side_sda, side_scl, side_ok;
    logic             qual_clear, blank_load, blank_expired;
    logic             vout_edge, en_rise, fault_rise, force_join;

    core_regs_t q, d;

    assign raw_lines = {out_scl_i, out_sda_i, in_scl_i, in_sda_i};

    bjc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_lines),
        .q_o    (sync_lines)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        assign side_sda[g] = sync_lines[2*g];
        assign side_scl[g] = sync_lines[2*g+1];
        bjc_side_qual #(.IDLE_CYCLES(IDLE_CYCLES)) u_qual (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (qual_clear),
            .sda_i   (side_sda[g]),
            .scl_i   (side_scl[g]),
            .ok_o    (side_ok[g])
        );
    end

    bjc_blank_timer #(.CYCLES(BLANK_CYCLES)) u_blank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (blank_load),
        .expired_o (blank_expired)
    );

    assign qual_clear = (q.st != ST_WAIT);

    always_comb begin
        d            = q;
        d.en_prev    = en_i;
        d.fault_prev = fault_i;
        d.vout_prev  = vout_ok_i;
        vout_edge    = (vout_ok_i != q.vout_prev) && (q.st != ST_LOCK);
        en_rise      = en_i && !q.en_prev;
        fault_rise   = fault_i && !q.fault_prev;
        force_join   = q.fault_seen && en_rise && (q.st != ST_BLANK);
        blank_load   = 1'b0;

        if (!pwr_good_i) begin
            d.st         = ST_LOCK;
            d.pre        = 1'b1;
            d.acc        = 1'b0;
            d.fault_seen = 1'b0;
        end else begin
            if (fault_i) d.fault_seen = 1'b1;
            if (vout_edge) begin
                d.st       = ST_BLANK;
                d.acc      = 1'b0;
                blank_load = 1'b1;
            end else if (q.st == ST_BLANK) begin
                if (blank_expired) d.st = ST_WAIT;
            end else if (force_join) begin
                d.st         = ST_JOIN;
                d.pre        = 1'b0;
                d.acc        = acc_allows(acc_mode_i);
                d.fault_seen = 1'b0;
            end else begin
                unique case (q.st)
                    ST_LOCK: d.st = ST_WAIT;
                    ST_WAIT: begin
                        if (disc_on_fault_i && fault_i) begin
                            d.st = ST_FHOLD;
                        end else if (en_i && (&side_ok)) begin
                            d.st         = ST_JOIN;
                            d.pre        = 1'b0;
                            d.acc        = acc_allows(acc_mode_i);
                            d.fault_seen = 1'b0;
                        end
                    end
                    ST_JOIN: begin
                        if (!en_i) begin
                            d.st  = ST_WAIT;
                            d.acc = 1'b0;
                        end else if (disc_on_fault_i && fault_rise) begin
                            d.st  = ST_FHOLD;
                            d.acc = 1'b0;
                        end
                    end
                    ST_FHOLD: if (!fault_i) d.st = ST_WAIT;
                    default:  d.st = ST_WAIT;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_LOCK, pre: 1'b1, acc: 1'b0, fault_seen: 1'b0,
                   en_prev: 1'b0, fault_prev: 1'b0, vout_prev: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign join_o      = (q.st == ST_JOIN);
    assign ready_o     = join_o;
    assign precharge_o = q.pre;
    assign accel_o     = q.acc;

    // R1: lockout holds everything off and precharge on
    p_lockout_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_good_i |=> (!join_o && precharge_o && !accel_o));

    // R5: a join always comes with precharge off
    p_join_no_pre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(join_o) |-> !precharge_o);

    // R5: precharge only comes back through lockout
    p_pre_only_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(precharge_o) |-> $past(!pwr_good_i));

    // R6: accelerators never run with the sides apart
    p_accel_needs_join_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accel_o |-> join_o);

    // R7: an output supply edge separates the sides
    p_vout_split_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_good_i && q.st != ST_LOCK && vout_ok_i != q.vout_prev) |=> (!join_o && !accel_o));

    // R8: a new fault with separation enabled splits a joined link
    p_fault_split_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_good_i && join_o && en_i && disc_on_fault_i && fault_rise && !vout_edge)
        |=> !join_o);

    // R9: faults are harmless when separation is disabled
    p_fault_benign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_good_i && join_o && en_i && !disc_on_fault_i && !vout_edge) |=> join_o);

    // R10: an enable toggle after a fault forces a join
    p_force_join_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_good_i && !vout_edge && q.st != ST_BLANK && q.fault_seen && en_rise)
        |=> join_o);
endmodule

// File: tb/bus_join_ctrl_tb_top.sv
module bus_join_ctrl_tb_top;
    localparam int IDLE  = 24;
    localparam int BLANK = 4750;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_sda = 1'b1, in_scl = 1'b1, out_sda = 1'b1, out_scl = 1'b1;
    logic en = 1'b1, pwr = 1'b0, vout = 1'b1, fault = 1'b0, disc = 1'b1;
    logic [1:0] acc = 2'b00;
    logic join_w, ready_w, pre_w, accel_w;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_join_ctrl #(.CLK_HZ(50_000_000), .BLANK_US(95), .IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .in_sda_i(in_sda), .in_scl_i(in_scl), .out_sda_i(out_sda), .out_scl_i(out_scl),
        .en_i(en), .pwr_good_i(pwr), .vout_ok_i(vout), .fault_i(fault),
        .disc_on_fault_i(disc), .acc_mode_i(acc),
        .join_o(join_w), .ready_o(ready_w), .precharge_o(pre_w), .accel_o(accel_w)
    );

    function automatic logic exp_accel(input logic [1:0] m);
        return (m == 2'b00) || (m == 2'b10);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic lines(input logic a, input logic b, input logic c, input logic e);
        in_sda = a; in_scl = b; out_sda = c; out_scl = e;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] latched_mode;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 reset join", join_w, 1'b0);
        chk("R1 reset precharge", pre_w, 1'b1);

        // R1: lockout ignores idle lines and STOP patterns
        cyc(40);
        in_sda = 1'b0; cyc(3); in_sda = 1'b1; cyc(30);
        chk("R1 lockout join", join_w, 1'b0);
        chk("R1 lockout ready", ready_w, 1'b0);
        chk("R1 lockout precharge", pre_w, 1'b1);
        chk("R1 lockout accel", accel_w, 1'b0);

        // R4 idle join on both sides
        pwr = 1'b1;
        cyc(10);
        chk("R4 no join before idle", join_w, 1'b0);
        cyc(IDLE + 10);
        chk("R4 idle join", join_w, 1'b1);
        chk("R5 ready on join", ready_w, 1'b1);
        chk("R5 precharge off", pre_w, 1'b0);
        chk("R6 accel low mode", accel_w, exp_accel(2'b00));

        // R11 enable low separates
        lines(1'b0, 1'b1, 1'b0, 1'b0);
        acc = 2'b01;
        cyc(2);
        en = 1'b0;
        cyc(2);
        chk("R11 enable low split", join_w, 1'b0);
        chk("R5 ready low when apart", ready_w, 1'b0);
        chk("R5 precharge stays off", pre_w, 1'b0);
        chk("R6 accel cleared on split", accel_w, 1'b0);
        en = 1'b1;
        cyc(40);
        chk("R2 both busy no join", join_w, 1'b0);
        out_sda = 1'b1; out_scl = 1'b1;
        cyc(40);
        chk("R2 one side only", join_w, 1'b0);
        in_sda = 1'b1;               // STOP on input side
        cyc(6);
        chk("R3 stop plus idle join", join_w, 1'b1);
        chk("R6 accel high mode", accel_w, exp_accel(2'b01));
        acc = 2'b00;
        cyc(5);
        chk("R6 mode change ignored", accel_w, 1'b0);

        // R9 fault without separation
        disc = 1'b0; fault = 1'b1;
        cyc(10);
        chk("R9 fault benign", join_w, 1'b1);
        fault = 1'b0; disc = 1'b1;
        cyc(3);

        // R8 fault with separation
        lines(1'b0, 1'b0, 1'b0, 1'b0);
        fault = 1'b1;
        cyc(2);
        chk("R8 fault split", join_w, 1'b0);
        chk("R5 ready low on fault", ready_w, 1'b0);
        lines(1'b1, 1'b1, 1'b1, 1'b1);
        cyc(40);
        chk("R8 held while fault", join_w, 1'b0);
        fault = 1'b0;
        cyc(5);
        chk("R8 requalify needed", join_w, 1'b0);
        cyc(IDLE + 10);
        chk("R8 rejoin after idle", join_w, 1'b1);

        // R10 forced join by enable toggle
        fault = 1'b1;
        in_sda = 1'b0;
        cyc(3);
        chk("R8 second fault split", join_w, 1'b0);
        en = 1'b0; cyc(3);
        en = 1'b1; cyc(2);
        chk("R10 forced join", join_w, 1'b1);
        chk("R6 accel on forced join", accel_w, exp_accel(acc));
        cyc(10);
        chk("R10 stays joined", join_w, 1'b1);
        fault = 1'b0;
        in_sda = 1'b1;
        cyc(3);

        // R7 blanking after output supply edge
        vout = 1'b0;
        cyc(2);
        chk("R7 vout split", join_w, 1'b0);
        chk("R7 accel off", accel_w, 1'b0);
        chk("R7 precharge unchanged", pre_w, 1'b0);
        cyc(BLANK + IDLE - 12);
        chk("R7 blanked", join_w, 1'b0);
        cyc(20);
        chk("R7 rejoin after blank", join_w, 1'b1);

        // R10 versus R7 in the same cycle
        disc = 1'b0; fault = 1'b1; cyc(3); fault = 1'b0; disc = 1'b1;
        in_sda = 1'b0;
        cyc(2);
        en = 1'b0; cyc(2);
        en = 1'b1; vout = 1'b1;
        cyc(2);
        chk("R10 blank wins over force", join_w, 1'b0);
        cyc(200);
        chk("R7 still blanked", join_w, 1'b0);
        cyc(BLANK);
        chk("R2 busy after blank", join_w, 1'b0);
        in_sda = 1'b1;
        cyc(IDLE + 10);
        chk("R2 join after blank idle", join_w, 1'b1);

        // R1 supply edge during lockout is ignored
        pwr = 1'b0;
        cyc(2);
        chk("R1 lockout split", join_w, 1'b0);
        chk("R1 precharge back", pre_w, 1'b1);
        vout = 1'b0;
        cyc(5);
        pwr = 1'b1;
        cyc(IDLE + 10);
        chk("R1 no blank from lockout edge", join_w, 1'b1);
        latched_mode = acc;

        // random bus traffic while joined
        for (int i = 0; i < 300; i++) begin
            lines(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            acc = 2'($urandom);
            cyc(1);
            chk("R5 joined under traffic", ready_w, 1'b1);
            chk("R6 latched accel", accel_w, exp_accel(latched_mode));
        end

        // random traffic with input SCL low: no qualification
        lines(1'b1, 1'b0, 1'b1, 1'b1);
        en = 1'b0; cyc(2); en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            in_sda = 1'($urandom);
            out_sda = 1'($urandom);
            out_scl = 1'($urandom);
            cyc(1);
            chk("R2 no join while busy", join_w, 1'b0);
        end

        // STOP on both sides together
        lines(1'b0, 1'b1, 1'b0, 1'b1);
        cyc(5);
        in_sda = 1'b1; out_sda = 1'b1;
        cyc(6);
        chk("R3 dual stop join", join_w, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule